// File: doc/BRIEF.md
# Arrival-Ordered Reader-Writer Grant Arbiter

This block grants shared access to a group of requesters, each of which asks for either read access or write access. Requests are served strictly in the order they are accepted. The arbiter groups them into phases. A phase is a run of consecutive requests of one kind. A read phase is granted as a whole, so its members run together. A write phase hands out its grants one member at a time. As a result, every read sees exactly the writes accepted before it and none accepted after it.

A requester presents a one-cycle request, together with its index and the access kind, while `req_ready` is high. It then waits for its `grant` bit and pulses its `done` bit when finished. Internally, a FIFO of requester indices keeps the arrival order, and a small queue of phases records each phase's kind and member count. The member count of the head phase decides how many indices leave the index FIFO and receive grants.

Top module: `rw_phase_arbiter`

## Requirements
- R1: After reset, every `grant` bit is 0 and `req_ready` is 1.
- R2: `req_ready` is 0 while the phase queue holds PH_DEPTH phases or the index FIFO holds IDX_DEPTH entries. A request presented while `req_ready` is 0 is not taken and never receives a grant.
- R3: An accepted request whose kind (`req_write`: 1 = write, 0 = read) matches the newest queued phase joins that phase as one more member, and no new phase is opened.
- R4: An accepted request whose kind differs from the newest phase, or that arrives when no phase is queued, opens a new phase at the tail of the queue.
- R5: While the head phase is a read phase, all of its members are granted in the same cycle.
- R6: While the head phase is a write phase, at most one grant is high at a time. Its members are granted in arrival order, and each member is granted only after the previous member's `done`.
- R7: Phases are granted strictly in arrival order. No member of a later phase is granted until every member of every earlier phase has signalled `done`.
- R8: A `grant[i]` bit, where bit i belongs to requester index i, stays high until `done[i]` is sampled high, and it falls at that clock edge.
- R9: When the last outstanding `done` of the head phase is sampled at a clock edge, the phase retires there, and the grants of the next phase rise at the following clock edge.
- R10: A request accepted at a clock edge while no phase is queued is granted at the next clock edge.
- R11: A `done` pulse for a requester whose grant is low has no effect on any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | Access kind of the request: 1 = write, 0 = read |
| req_id | input | $clog2(N_REQ) | Binary index of the requesting agent |
| req_ready | output | 1 | The arbiter can take a request this cycle |
| done | input | N_REQ | Per-requester release pulse |
| grant | output | N_REQ | Per-requester access grant |

## Verification
On every cycle, the embedded properties check four things. A write head never has more than one grant high. A grant bit falls only on its own `done`. The counts of issued and released members stay ordered within the head phase's size. Neither queue is overrun or popped while empty. Only the bench scenarios can show the rest: whether a whole read run is granted together, whether the phases follow arrival order for every kind pattern of four requests, the exact edge at which a new or following phase is granted, and that stray `done` pulses and held-off requests leave the grants untouched.

// File: rtl/rwpa_pkg.sv
package rwpa_pkg;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;

   // circular pointer advance for a queue of arbitrary depth
   function automatic int ring_next(input int ptr, input int depth);
      return (ptr == depth - 1) ? 0 : ptr + 1;
   endfunction

endpackage

// File: rtl/rwpa_phase_queue.sv
module rwpa_phase_queue
   import rwpa_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  acc_kind_e     push_kind,
   input  logic          pop_en,
   output logic          full,
   output logic          head_valid,
   output acc_kind_e     head_kind,
   output logic [CW-1:0] head_cnt,
   output logic          head_join
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rwpa_phase_queue: DEPTH must be at least 2");
   end

   acc_kind_e     kind_q [DEPTH];
   logic [CW-1:0] cnt_q  [DEPTH];
   logic [PW-1:0] rd_q, wr_q, tail_p;
   logic [NW-1:0] num_q;
   logic          joins, opens;

   always_comb begin
      tail_p = (wr_q == '0) ? PW'(DEPTH - 1) : wr_q - PW'(1);
      joins  = push_en && (num_q != '0) && (kind_q[tail_p] == push_kind);
      opens  = push_en && !joins;
   end

   assign head_join  = joins && (num_q == NW'(1));
   assign full       = (num_q == NW'(DEPTH));
   assign head_valid = (num_q != '0);
   assign head_kind  = kind_q[rd_q];
   assign head_cnt   = cnt_q[rd_q];

   always_ff @(posedge clk) begin
      if (joins) begin
         cnt_q[tail_p] <= cnt_q[tail_p] + CW'(1);
      end
      if (opens) begin
         kind_q[wr_q] <= push_kind;
         cnt_q[wr_q]  <= CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         num_q <= '0;
      end else begin
         if (opens)  wr_q <= PW'(ring_next(int'(wr_q), DEPTH));
         if (pop_en) rd_q <= PW'(ring_next(int'(rd_q), DEPTH));
         num_q <= num_q + NW'(opens) - NW'(pop_en);
      end
   end

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      num_q <= NW'(DEPTH));

   p_no_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> (num_q != '0));

endmodule

// File: rtl/rwpa_index_fifo.sv
module rwpa_index_fifo #(
   parameter int DEPTH = 8,
   parameter int IDW   = 3,
   parameter int CW    = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_en,
   input  logic [IDW-1:0] push_id,
   input  logic [CW-1:0]  pop_n,
   output logic [IDW-1:0] peek [DEPTH],
   output logic           full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rwpa_index_fifo: DEPTH must be at least 2");
   end

   logic [IDW-1:0] mem [DEPTH];
   logic [PW-1:0]  rd_q, wr_q, rd_nxt;
   logic [CW-1:0]  num_q;

   // window of the oldest entries, oldest first
   for (genvar k = 0; k < DEPTH; k++) begin : g_peek
      always_comb begin
         int s;
         s = int'(rd_q) + k;
         if (s >= DEPTH) s = s - DEPTH;
         peek[k] = mem[s];
      end
   end

   always_comb begin
      int s;
      s = int'(rd_q) + int'(pop_n);
      if (s >= DEPTH) s = s - DEPTH;
      rd_nxt = PW'(s);
   end

   assign full = (num_q == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push_en) mem[wr_q] <= push_id;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         num_q <= '0;
      end else begin
         if (push_en) wr_q <= PW'(rwpa_pkg::ring_next(int'(wr_q), DEPTH));
         rd_q  <= rd_nxt;
         num_q <= num_q + CW'(push_en) - pop_n;
      end
   end

   p_pop_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop_n <= num_q);

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push_en);

endmodule

// File: rtl/rw_phase_arbiter.sv
module rw_phase_arbiter
   import rwpa_pkg::*;
#(
   parameter int N_REQ     = 8,
   parameter int PH_DEPTH  = 4,
   parameter int IDX_DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [$clog2(N_REQ)-1:0] req_id,
   output logic                     req_ready,
   input  logic [N_REQ-1:0]         done,
   output logic [N_REQ-1:0]         grant
);

   localparam int IDW = $clog2(N_REQ);
   localparam int CW  = $clog2(IDX_DEPTH + 1);

   if (N_REQ < 2) begin : g_bad_nreq
      $error("rw_phase_arbiter: N_REQ must be at least 2");
   end
   if (IDX_DEPTH < N_REQ) begin : g_bad_idx
      $error("rw_phase_arbiter: IDX_DEPTH must cover every requester");
   end

   logic           accept;
   logic           ph_full, ix_full;
   logic           head_valid, head_join, retire;
   acc_kind_e      head_kind;
   logic [CW-1:0]  head_cnt;
   logic [IDW-1:0] peek [IDX_DEPTH];

   logic [N_REQ-1:0] grant_q, new_g, done_hit;
   logic [CW-1:0]    iss_q, dn_q, n_issue, n_done, remaining;

   assign req_ready = !ph_full && !ix_full;
   assign accept    = req_valid && req_ready;

   rwpa_phase_queue #(.DEPTH(PH_DEPTH), .CW(CW)) u_phases (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_en    (accept),
      .push_kind  (acc_kind_e'(req_write)),
      .pop_en     (retire),
      .full       (ph_full),
      .head_valid (head_valid),
      .head_kind  (head_kind),
      .head_cnt   (head_cnt),
      .head_join  (head_join)
   );

   rwpa_index_fifo #(.DEPTH(IDX_DEPTH), .IDW(IDW), .CW(CW)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_en (accept),
      .push_id (req_id),
      .pop_n   (n_issue),
      .peek    (peek),
      .full    (ix_full)
   );

   // issue decision for the head phase
   always_comb begin
      new_g     = '0;
      n_issue   = '0;
      remaining = head_cnt - iss_q;
      if (head_valid) begin
         if (head_kind == ACC_READ) begin
            for (int k = 0; k < IDX_DEPTH; k++) begin
               if (CW'(k) < remaining && int'(peek[k]) < N_REQ) begin
                  new_g[peek[k]] = 1'b1;
               end
            end
            n_issue = remaining;
         end else if (iss_q == dn_q && iss_q < head_cnt) begin
            if (int'(peek[0]) < N_REQ) new_g[peek[0]] = 1'b1;
            n_issue = CW'(1);
         end
      end
   end

   // release accounting
   always_comb begin
      done_hit = done & grant_q;
      n_done   = CW'($countones(done_hit));
      retire   = head_valid &&
                 ((int'(dn_q) + int'(n_done)) == (int'(head_cnt) + int'(head_join)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         iss_q   <= '0;
         dn_q    <= '0;
      end else begin
         grant_q <= (grant_q & ~done_hit) | new_g;
         if (retire) begin
            iss_q <= '0;
            dn_q  <= '0;
         end else begin
            iss_q <= iss_q + n_issue;
            dn_q  <= dn_q + n_done;
         end
      end
   end

   assign grant = grant_q;

   p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && head_kind == ACC_WRITE) |-> ($countones(grant_q) <= 1));

   p_issue_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |-> (dn_q <= iss_q && iss_q <= head_cnt));

   for (genvar i = 0; i < N_REQ; i++) begin : g_hold
      p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_q[i] && !done[i]) |=> grant_q[i]);
   end

endmodule

// File: tb/rw_phase_arbiter_tb.sv
`timescale 1ns/1ps
module rw_phase_arbiter_tb;

   localparam int N   = 8;
   localparam int IDW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic [IDW-1:0] req_id = '0;
   logic           req_ready;
   logic [N-1:0]   done = '0;
   logic [N-1:0]   grant;

   int vectors = 0;
   int misses  = 0;

   always #2.5 clk = ~clk;

   rw_phase_arbiter #(.N_REQ(N), .PH_DEPTH(4), .IDX_DEPTH(8)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_id    (req_id),
      .req_ready (req_ready),
      .done      (done),
      .grant     (grant)
   );

   task automatic chk_g(input string tag, input logic [N-1:0] exp);
      vectors++;
      if (grant !== exp) begin
         misses++;
         $display("FAIL %s: grant=%b expected %b", tag, grant, exp);
      end
   endtask

   task automatic chk_rdy(input string tag, input logic exp);
      vectors++;
      if (req_ready !== exp) begin
         misses++;
         $display("FAIL %s: req_ready=%b expected %b", tag, req_ready, exp);
      end
   endtask

   task automatic issue(input int id, input logic wr);
      @(negedge clk);
      req_valid = 1'b1;
      req_id    = IDW'(id);
      req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic release_mask(input logic [N-1:0] m);
      @(negedge clk);
      done = m;
      @(negedge clk);
      done = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      misses++;
      vectors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_g("R1 reset grant", '0);
      chk_rdy("R1 reset ready", 1'b1);

      // sweep every read/write pattern of four arrivals (bit i set = write)
      for (int pat = 0; pat < 16; pat++) begin
         int i;
         for (int r = 0; r < 4; r++) issue(r, pat[r]);
         idle(3);
         i = 0;
         while (i < 4) begin
            logic [N-1:0] m;
            m = '0;
            if (!pat[i]) begin
               while (i < 4 && !pat[i]) begin
                  m[i] = 1'b1;
                  i++;
               end
               chk_g($sformatf("R3 R5 R7 read run pat=%0d", pat), m);
            end else begin
               m[i] = 1'b1;
               i++;
               chk_g($sformatf("R4 R6 R7 write step pat=%0d", pat), m);
            end
            release_mask(m);
            idle(2);
         end
         chk_g($sformatf("R7 drained pat=%0d", pat), '0);
      end

      // timing of a request into an empty arbiter
      @(negedge clk);
      req_valid = 1'b1; req_id = 3'd5; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk_g("R10 not yet granted", '0);
      @(negedge clk);
      chk_g("R10 granted next edge", 8'b0010_0000);

      // a reader queues behind the writer; a stray done changes nothing
      issue(6, 1'b0);
      release_mask(8'b0000_0100);
      chk_g("R11 stray done ignored", 8'b0010_0000);

      // retirement and hand-over timing
      @(negedge clk);
      done = 8'b0010_0000;
      @(negedge clk);
      done = '0;
      chk_g("R8 R9 grant dropped, next not yet", '0);
      @(negedge clk);
      chk_g("R9 next phase granted", 8'b0100_0000);
      release_mask(8'b0100_0000);
      idle(2);
      chk_g("R9 idle after drain", '0);

      // fill the phase queue with alternating kinds
      issue(0, 1'b1);
      issue(1, 1'b0);
      issue(2, 1'b1);
      issue(3, 1'b0);
      idle(2);
      chk_rdy("R2 phase queue full", 1'b0);
      @(negedge clk);
      req_valid = 1'b1; req_id = 3'd4; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk_rdy("R2 still full", 1'b0);
      for (int s = 0; s < 4; s++) begin
         logic [N-1:0] m;
         m = '0;
         m[s] = 1'b1;
         chk_g($sformatf("R2 R7 drain step %0d", s), m);
         release_mask(m);
         idle(2);
      end
      chk_g("R2 held-off request never granted", '0);
      chk_rdy("R2 ready after drain", 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule